// File: doc/BRIEF.md
# Bulk Receive Stream Deframer

This block sits behind a bulk-in endpoint and takes one transfer buffer as a byte stream. The transfer holds several Ethernet frames packed back to back. Every packed frame starts with a three-byte header: a status byte, then a 16-bit length sent low byte first. The length counts the payload plus a four-byte frame check sequence (FCS), which follows the payload. The deframer removes the header and the FCS. It forwards only payload bytes and raises `out_last` on the final byte of each frame. The input marks the end of the transfer with `in_last`.

Two checks guard each header. The status byte must equal a magic value (0x40 by default). The length field must give a payload of 1 to `MAX_PAYLOAD` bytes, which is 1514 by default. When a check fails, the rest of the transfer is consumed and thrown away, and a drop counter steps once. If a transfer ends partway through a frame's payload or FCS, the frame's last forwarded byte carries `out_last` together with `out_err`. A transfer that ends inside a header produces nothing.

The final payload byte of each frame is held in a one-byte register while the four FCS bytes are consumed. It is released only once it is known whether the FCS arrived complete.

The state machine has seven states:
- `ST_STAT` waits for the status byte. A good, non-final status byte moves to `ST_LEN_LO`. A bad one moves to `ST_SKIP`. A status byte flagged last stays in `ST_STAT`.
- `ST_LEN_LO` takes the low length byte and moves to `ST_LEN_HI`. It returns to `ST_STAT` on last.
- `ST_LEN_HI` takes the high length byte and moves to `ST_BODY` if the length is valid, or to `ST_SKIP` if not. It returns to `ST_STAT` on last.
- `ST_BODY` forwards payload bytes and returns to `ST_STAT` on a truncating last. On the final payload byte it captures the byte and moves to `ST_TRAIL`, or to `ST_TAIL` if that byte is flagged last.
- `ST_TRAIL` consumes the FCS and moves to `ST_TAIL` after the fourth FCS byte or on last.
- `ST_TAIL` presents the held byte and moves to `ST_STAT` on `out_ready`.
- `ST_SKIP` consumes bytes until last, then moves to `ST_STAT`.

Top module: `bulk_rx_deframer`

## Requirements
- R1: After reset, `out_valid` is 0, `drop_count` is 0 and `in_ready` is 1. The block waits for a status byte.
- R2: The header is a status byte, then length low, then length high. The payload length is the 16-bit field minus 4. Exactly that many payload bytes are forwarded, in order. No header or FCS byte is ever forwarded.
- R3: When the full four-byte FCS follows the payload, the final payload byte is presented with `out_last`=1 and `out_err`=0. It is presented only after all four FCS bytes have been accepted.
- R4: One transfer may carry any number of frames back to back. Each one is forwarded as a separate frame.
- R5: A status byte other than 0x40 that is not flagged last causes every remaining byte of the transfer to be discarded, up to and including the byte with `in_last`. `drop_count` increases by 1.
- R6: A length field above 1518 (payload above 1514) that is not the last byte causes the rest of the transfer to be discarded, and `drop_count` increases by 1. A field of exactly 1518 is accepted.
- R7: A length field of 4 or less (payload of zero or fewer bytes) that is not the last byte is treated like an oversize length. The rest of the transfer is discarded and `drop_count` increases by 1.
- R8: If `in_last` arrives in the payload or within the FCS, the frame's last forwarded byte carries `out_last`=1 and `out_err`=1. The next byte is parsed as a status byte.
- R9: If `in_last` arrives on a header byte, nothing is forwarded and `drop_count` does not change, even if the status byte is bad. The next byte is parsed as a status byte.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output byte and its flags hold, and no input byte is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Transfer byte |
| in_valid | input | 1 | Transfer byte valid |
| in_last | input | 1 | Final byte of the transfer |
| in_ready | output | 1 | Block accepts the transfer byte |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | Payload byte valid |
| out_last | output | 1 | Final byte of a frame |
| out_err | output | 1 | Frame was truncated (valid with `out_last`) |
| out_ready | input | 1 | Downstream accepts the payload byte |
| drop_count | output | CNT_W | Transfers abandoned on a bad header |

## Verification
The state machine itself cannot be seen at the ports, so the checks look for its effects there. A wrong state or a miscounted remaining length shows up in the forwarded stream of the transfer it affects. It appears as header or FCS bytes leaking out, a frame cut short or run long, or `out_last` landing on the wrong byte. A parser left out of step at the end of a transfer corrupts the first frame of the next transfer. Discard decisions show in `drop_count` one cycle after the offending header byte is accepted, and in the missing frames that follow it.

// File: rtl/deframe_pkg.sv
`timescale 1ns/1ps
package deframe_pkg;
    typedef enum logic [2:0] {
        ST_STAT,
        ST_LEN_LO,
        ST_LEN_HI,
        ST_BODY,
        ST_TRAIL,
        ST_TAIL,
        ST_SKIP
    } dfr_state_e;
endpackage

// File: rtl/dfr_hdr_check.sv
`timescale 1ns/1ps
module dfr_hdr_check #(
    parameter int LEN_W       = 16,
    parameter int MAX_PAYLOAD = 1514,
    parameter int TRAIL_BYTES = 4
) (
    input  logic [LEN_W-1:0] len_field,
    output logic             len_ok,
    output logic [LEN_W-1:0] body_len
);
    localparam logic [LEN_W-1:0] TRAIL_L   = LEN_W'(TRAIL_BYTES);
    localparam logic [LEN_W-1:0] MAX_FIELD = LEN_W'(MAX_PAYLOAD + TRAIL_BYTES);

    always_comb begin
        len_ok   = (len_field > TRAIL_L) && (len_field <= MAX_FIELD);
        body_len = len_field - TRAIL_L;
    end
endmodule

// File: rtl/dfr_drop_ctr.sv
`timescale 1ns/1ps
module dfr_drop_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (bump) count <= count + CNT_W'(1);
    end

    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        bump |=> count == $past(count) + CNT_W'(1)); // R5
    AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bump |=> count == $past(count)); // R9
endmodule

// File: rtl/bulk_rx_deframer.sv
`timescale 1ns/1ps
module bulk_rx_deframer
    import deframe_pkg::*;
#(
    parameter logic [7:0] MAGIC       = 8'h40,
    parameter int         MAX_PAYLOAD = 1514,
    parameter int         CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    input  logic             in_last,
    output logic             in_ready,
    output logic [7:0]       out_data,
    output logic             out_valid,
    output logic             out_last,
    output logic             out_err,
    input  logic             out_ready,
    output logic [CNT_W-1:0] drop_count
);
    localparam int LEN_W       = 16;
    localparam int TRAIL_BYTES = 4;
    localparam int TRAIL_W     = $clog2(TRAIL_BYTES);
    localparam logic [TRAIL_W-1:0] TRAIL_END = TRAIL_W'(TRAIL_BYTES - 1);

    dfr_state_e        state, state_nx;
    logic [7:0]        len_lo;
    logic [LEN_W-1:0]  rem;
    logic [TRAIL_W-1:0] fcnt;
    logic [7:0]        hold_byte;
    logic              hold_err;
    logic              bump;
    logic              len_ok;
    logic [LEN_W-1:0]  body_len;
    logic              in_fire;
    logic              body_final;

    assign in_fire    = in_valid && in_ready;
    assign body_final = (rem == LEN_W'(1));

    dfr_hdr_check #(.LEN_W(LEN_W), .MAX_PAYLOAD(MAX_PAYLOAD), .TRAIL_BYTES(TRAIL_BYTES)) u_hdr (
        .len_field ({in_data, len_lo}),
        .len_ok    (len_ok),
        .body_len  (body_len)
    );

    dfr_drop_ctr #(.CNT_W(CNT_W)) u_drop (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (bump),
        .count (drop_count)
    );

    // state and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_STAT;
            len_lo    <= '0;
            rem       <= '0;
            fcnt      <= '0;
            hold_byte <= '0;
            hold_err  <= 1'b0;
        end else begin
            state <= state_nx;
            if (in_fire) begin
                unique case (state)
                    ST_LEN_LO: len_lo <= in_data;
                    ST_LEN_HI: rem    <= body_len;
                    ST_BODY: begin
                        rem <= rem - LEN_W'(1);
                        if (body_final) begin
                            hold_byte <= in_data;
                            hold_err  <= in_last;
                            fcnt      <= '0;
                        end
                    end
                    ST_TRAIL: begin
                        fcnt <= fcnt + TRAIL_W'(1);
                        if (in_last && fcnt != TRAIL_END) hold_err <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // next state and drop decision
    always_comb begin
        state_nx = state;
        bump     = 1'b0;
        unique case (state)
            ST_STAT: if (in_fire && !in_last) begin
                if (in_data == MAGIC) state_nx = ST_LEN_LO;
                else begin
                    state_nx = ST_SKIP;
                    bump     = 1'b1;
                end
            end
            ST_LEN_LO: if (in_fire) state_nx = in_last ? ST_STAT : ST_LEN_HI;
            ST_LEN_HI: if (in_fire) begin
                if (in_last)     state_nx = ST_STAT;
                else if (len_ok) state_nx = ST_BODY;
                else begin
                    state_nx = ST_SKIP;
                    bump     = 1'b1;
                end
            end
            ST_BODY: if (in_fire) begin
                if (body_final)   state_nx = in_last ? ST_TAIL : ST_TRAIL;
                else if (in_last) state_nx = ST_STAT;
            end
            ST_TRAIL: if (in_fire && (in_last || fcnt == TRAIL_END)) state_nx = ST_TAIL;
            ST_TAIL:  if (out_ready) state_nx = ST_STAT;
            ST_SKIP:  if (in_fire && in_last) state_nx = ST_STAT;
            default:  state_nx = ST_STAT;
        endcase
    end

    // port outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = in_data;
        out_last  = 1'b0;
        out_err   = 1'b0;
        unique case (state)
            ST_BODY: begin
                if (body_final) in_ready = 1'b1;
                else begin
                    in_ready  = out_ready;
                    out_valid = in_valid;
                    out_last  = in_last;
                    out_err   = in_last;
                end
            end
            ST_TAIL: begin
                out_valid = 1'b1;
                out_data  = hold_byte;
                out_last  = 1'b1;
                out_err   = hold_err;
            end
            default: in_ready = 1'b1;
        endcase
    end

    AST_TAIL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL && !out_ready) |=> (out_valid && out_last && $stable(out_data) && $stable(out_err))); // R10
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SKIP |-> !out_valid); // R5
    AST_BODY_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_BODY |-> rem != '0); // R7
    AST_CLEAN_END: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last && !out_err) |-> state == ST_TAIL); // R3
    AST_HDR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STAT || state == ST_LEN_LO || state == ST_LEN_HI) |-> !out_valid); // R9
    AST_TRAIL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRAIL && in_fire && fcnt == TRAIL_END) |=> state == ST_TAIL); // R3
endmodule

// File: tb/sim_bulk_rx_deframer.sv
`timescale 1ns/1ps
module sim_bulk_rx_deframer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  in_data;
    logic        in_valid;
    logic        in_last;
    logic        in_ready;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_last;
    logic        out_err;
    logic        out_ready;
    logic [15:0] drop_count;

    int checks = 0;
    int fails  = 0;
    int exp_drop = 0;
    bit gap_en = 0;
    bit stall_en = 0;
    logic [7:0] tx_q[$];
    logic [9:0] exp_q[$];
    logic [9:0] got_q[$];

    always #5 clk = ~clk;

    bulk_rx_deframer u0 (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_err(out_err),
        .out_ready(out_ready), .drop_count(drop_count)
    );

    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk); #1;
            out_ready = stall_en ? ($urandom_range(3) != 0) : 1'b1;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid && out_ready) got_q.push_back({out_err, out_last, out_data});
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++; fails++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        finish_run();
    end

    task automatic push(input logic [7:0] b, input bit last);
        if (gap_en && $urandom_range(3) == 0) begin @(posedge clk); #1; end
        in_data = b; in_last = last; in_valid = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    // frame of plen payload bytes; keep only first cut bytes (cut<0: whole frame)
    task automatic add_frame(input int field, input int cut);
        int plen = field - 4;
        int total = plen + 7;
        int n = (cut < 0) ? total : cut;
        logic [7:0] fr[$];
        fr.push_back(8'h40); fr.push_back(field[7:0]); fr.push_back(field[15:8]);
        for (int i = 0; i < plen; i++) fr.push_back(8'($urandom_range(255)));
        for (int i = 0; i < 4; i++) fr.push_back(8'($urandom_range(255)));
        for (int i = 0; i < n; i++) tx_q.push_back(fr[i]);
        if (n == total) begin
            for (int i = 0; i < plen; i++) exp_q.push_back({1'b0, i == plen - 1, fr[3 + i]});
        end else if (n > 3) begin
            int k = (n - 3 < plen) ? n - 3 : plen;
            for (int i = 0; i < k; i++) exp_q.push_back({i == k - 1, i == k - 1, fr[3 + i]});
        end
    endtask

    task automatic add_garbage();
        int g = $urandom_range(1, 5);
        for (int i = 0; i < g; i++) tx_q.push_back(8'($urandom_range(255)));
    endtask

    task automatic add_bad_status();
        logic [7:0] s;
        do s = 8'($urandom_range(255)); while (s == 8'h40);
        tx_q.push_back(s);
        add_garbage();
        exp_drop++;
    endtask

    task automatic add_bad_len(input int field);
        tx_q.push_back(8'h40); tx_q.push_back(field[7:0]); tx_q.push_back(field[15:8]);
        add_garbage();
        exp_drop++;
    endtask

    task automatic send_transfer();
        for (int i = 0; i < tx_q.size(); i++) push(tx_q[i], i == tx_q.size() - 1);
        repeat (30) @(posedge clk);
        #1;
        tx_q.delete();
    endtask

    task automatic check_stream(input string tag);
        int bad = -1;
        checks++;
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            if (bad < 0 && exp_q[i] !== got_q[i]) bad = i;
        if (got_q.size() != exp_q.size()) begin
            fails++;
            $display("FAIL %s: byte count actual=%0d expected=%0d", tag, got_q.size(), exp_q.size());
        end else if (bad >= 0) begin
            fails++;
            $display("FAIL %s: entry %0d {err,last,data} actual=%h expected=%h", tag, bad, got_q[bad], exp_q[bad]);
        end
        exp_q.delete(); got_q.delete();
    endtask

    task automatic check_drop(input string tag);
        checks++;
        if (drop_count !== 16'(exp_drop)) begin
            fails++;
            $display("FAIL %s: drop_count actual=%0d expected=%0d", tag, drop_count, exp_drop);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
        repeat (4) @(posedge clk);
        #1;
        // R1 reset state
        checks++;
        if (out_valid !== 1'b0 || drop_count !== '0 || in_ready !== 1'b1) begin
            fails++;
            $display("FAIL R1: reset actual v=%b d=%0d r=%b expected v=0 d=0 r=1", out_valid, drop_count, in_ready);
        end
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R2 R3: one-byte payload, and a short frame
        add_frame(5, -1); send_transfer(); check_stream("R2_single_byte");
        add_frame(24, -1); send_transfer(); check_stream("R3_clean_end");

        // R4: several frames in one transfer
        add_frame(9, -1); add_frame(64, -1); add_frame(5, -1); add_frame(30, -1);
        send_transfer(); check_stream("R4_packed");

        // R6: boundary 1518 accepted, 1519 rejected
        add_frame(1518, -1); send_transfer(); check_stream("R6_max_ok");
        add_frame(12, -1); add_bad_len(1519); send_transfer(); check_stream("R6_oversize");
        check_drop("R6_drop");

        // R7: short length fields
        add_bad_len(4); send_transfer(); check_stream("R7_len4");
        add_frame(7, -1); add_bad_len(0); send_transfer(); check_stream("R7_len0");
        check_drop("R7_drop");

        // R5: bad status mid transfer hides the following good frame
        add_frame(10, -1); add_bad_status(); add_frame(10, -1);
        exp_q = exp_q[0:5];
        send_transfer(); check_stream("R5_bad_status");
        check_drop("R5_drop");

        // R8: truncation in body, at payload end, inside FCS
        add_frame(20, 10); send_transfer(); check_stream("R8_cut_body");
        add_frame(20, 19); send_transfer(); check_stream("R8_cut_payload_end");
        add_frame(20, 21); send_transfer(); check_stream("R8_cut_fcs");
        add_frame(8, -1); send_transfer(); check_stream("R8_recover");

        // R9: transfer ends inside a header, including bad single status byte
        add_frame(6, -1); add_frame(40, 2); send_transfer(); check_stream("R9_hdr_frag");
        tx_q.push_back(8'h55); send_transfer(); check_stream("R9_lone_status");
        add_frame(40, 3); send_transfer(); check_stream("R9_full_hdr_last");
        check_drop("R9_drop");

        // R10: random traffic with gaps and backpressure
        gap_en = 1; stall_en = 1;
        for (int t = 0; t < 40; t++) begin
            int nfr = $urandom_range(1, 3);
            int tail = $urandom_range(0, 5);
            for (int f = 0; f < nfr; f++) add_frame($urandom_range(5, 28), -1);
            if (tail == 2) begin
                int fl = $urandom_range(5, 28);
                add_frame(fl, $urandom_range(1, fl + 2));
            end else if (tail == 3) add_bad_status();
            else if (tail == 4) add_bad_len($urandom_range(1519, 65535));
            else if (tail == 5) add_bad_len($urandom_range(0, 4));
            send_transfer();
            check_stream("R10_random");
        end
        check_drop("R10_drop");
        finish_run();
    end
endmodule